// File: doc/BRIEF.md
# Accumulator Processor Core with Interrupt Check

This block is a small 16-bit accumulator processor. It steps through a fixed machine cycle. It fetches an instruction, decodes and executes it, and then checks for an interrupt. It works against one synchronous single-port memory that has a read latency of one cycle. The core holds a program counter, an instruction register, a memory address register, a memory buffer register and an accumulator. The memory address and the write data always come from the address register and the buffer register.

Each 16-bit instruction word has a 4-bit operation code in bits [15:12] and a 12-bit word address in bits [11:0]. The core can load the accumulator, store it and add to it. It can also jump, enable interrupts and return from an interrupt. After every instruction the core samples a single interrupt request line. If the request is high and interrupts are enabled, the core takes the interrupt. It copies the program counter and the accumulator into shadow registers, disables further interrupts and continues at a fixed handler address. The return instruction restores both registers and enables interrupts again.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_n` is low at a clock edge, the core clears the program counter, the accumulator and the interrupt enable. The core then starts with a fetch from address 0, and `mem_we` stays low.
- R2: Operation code 0001 loads the accumulator with the memory word at the address field.
- R3: Operation code 0101 adds the memory word at the address field to the accumulator, modulo 2^16. A carry out of bit 15 is lost.
- R4: Operation code 0010 writes the accumulator to the address field. `mem_we` is high for exactly one cycle, with `mem_wdata` equal to the accumulator.
- R5: A fetch reads the word at the program counter. The read data arrives one cycle after the address is presented, and the program counter then increases by one.
- R6: Operation code 1000 loads the program counter from the address field, so the next fetch comes from that address.
- R7: When interrupts are disabled, a high `irq` has no effect. Interrupts are disabled after reset and while a handler runs.
- R8: Operation code 0111 enables interrupts. With interrupts enabled, a high `irq` at the check that follows an instruction does three things: it saves the program counter and the accumulator, it disables interrupts and it moves the program counter to 0x100.
- R9: Operation code 1111 restores the saved program counter and accumulator and enables interrupts again.
- R10: All other operation codes leave the accumulator and the memory unchanged, and execution continues at the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_addr | output | 12 | Memory word address (address register) |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (buffer register) |
| mem_rdata | input | 16 | Memory read data, valid one cycle after the address |
| pc_o | output | 12 | Current program counter |
| acc_o | output | 16 | Current accumulator |
| irq_en_o | output | 1 | Interrupt enable flag |

## Verification
The bench adds two operands whose sum carries out of bit 15. A core that kept the carry or saturated would store a wrong sum. It places a jump over a store, and a decoder that fell through would write a word that must stay clear. It also executes an undefined operation code that would otherwise touch memory or the accumulator. The interrupt tests do three things. They hold `irq` high while interrupts are disabled, and any vectoring at that point would run the handler's marker store. They hold `irq` high well into a handler that counts its entries in memory, so a core that did not clear the enable would nest and count more than once. Last, the handler overwrites the accumulator before it returns, so a return that failed to restore the accumulator would show the handler's value instead of the program's.

// File: rtl/acc_cpu_pkg.sv
// Package acc_cpu_pkg
// Shared types of the accumulator core: the operation codes, the states of the
// machine cycle and the bundle of control strobes from sequencer to datapath.
// Assumes a 4-bit operation code in the top bits of each instruction word.
package acc_cpu_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'b0010;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_IEN   = 4'b0111;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_RETI  = 4'b1111;

    typedef enum logic [3:0] {
        ST_FETCH,
        ST_FWAIT,
        ST_FLOAD,
        ST_DECODE,
        ST_RWAIT,
        ST_RCAP,
        ST_EXEC,
        ST_WRITE,
        ST_ICHECK
    } cpu_state_e;

    typedef struct packed {
        logic mar_from_pc;
        logic mar_from_ir;
        logic ir_load;
        logic pc_inc;
        logic pc_jump;
        logic pc_vector;
        logic pc_restore;
        logic mbr_from_mem;
        logic mbr_from_acc;
        logic acc_load;
        logic acc_add;
        logic acc_restore;
        logic ctx_save;
        logic ie_set;
    } cpu_ctrl_t;

endpackage

// File: rtl/acc_cpu_alu.sv
// Module acc_cpu_alu
// Produces the value that the accumulator takes on a load or an add. With
// add_en low it passes the memory operand through; with add_en high it returns
// the sum modulo 2^W. Purely combinational; assumes both operands are W bits.
module acc_cpu_alu #(
    parameter int W = 16
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic         add_en,
    output logic [W-1:0] result
);

    // Select pass-through or wrapping sum.
    always_comb begin
        if (add_en) begin
            result = op_a + op_b;
        end else begin
            result = op_b;
        end
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
// Module acc_cpu_ctrl
// Sequencer of the machine cycle: fetch (address, wait, capture), decode,
// operand read (address, wait, capture, execute) or write, then one interrupt
// check state per instruction. Assumes memory read data is valid exactly one
// cycle after the address register changes.
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OPC_W-1:0] opcode,
    input  logic             irq,
    input  logic             ie,
    output cpu_state_e       state_o,
    output cpu_ctrl_t        ctl_o,
    output logic             mem_we_o
);

    cpu_state_e state_q;
    cpu_state_e state_d;

    // State register; reset lands on the first fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state and strobe decode for the current state.
    always_comb begin
        state_d  = state_q;
        ctl_o    = '0;
        mem_we_o = 1'b0;
        case (state_q)
            ST_FETCH: begin
                ctl_o.mar_from_pc = 1'b1;
                state_d = ST_FWAIT;
            end
            ST_FWAIT: begin
                state_d = ST_FLOAD;
            end
            ST_FLOAD: begin
                ctl_o.ir_load = 1'b1;
                ctl_o.pc_inc  = 1'b1;
                state_d = ST_DECODE;
            end
            ST_DECODE: begin
                state_d = ST_ICHECK;
                case (opcode)
                    OPC_LOAD, OPC_ADD: begin
                        ctl_o.mar_from_ir = 1'b1;
                        state_d = ST_RWAIT;
                    end
                    OPC_STORE: begin
                        ctl_o.mar_from_ir  = 1'b1;
                        ctl_o.mbr_from_acc = 1'b1;
                        state_d = ST_WRITE;
                    end
                    OPC_JUMP: begin
                        ctl_o.pc_jump = 1'b1;
                    end
                    OPC_IEN: begin
                        ctl_o.ie_set = 1'b1;
                    end
                    OPC_RETI: begin
                        ctl_o.pc_restore  = 1'b1;
                        ctl_o.acc_restore = 1'b1;
                        ctl_o.ie_set      = 1'b1;
                    end
                    default: begin
                        state_d = ST_ICHECK;
                    end
                endcase
            end
            ST_RWAIT: begin
                state_d = ST_RCAP;
            end
            ST_RCAP: begin
                ctl_o.mbr_from_mem = 1'b1;
                state_d = ST_EXEC;
            end
            ST_EXEC: begin
                ctl_o.acc_load = (opcode == OPC_LOAD);
                ctl_o.acc_add  = (opcode == OPC_ADD);
                state_d = ST_ICHECK;
            end
            ST_WRITE: begin
                mem_we_o = 1'b1;
                state_d  = ST_ICHECK;
            end
            ST_ICHECK: begin
                if (irq && ie) begin
                    ctl_o.ctx_save  = 1'b1;
                    ctl_o.pc_vector = 1'b1;
                end
                state_d = ST_FETCH;
            end
            default: begin
                state_d = ST_FETCH;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/acc_cpu_dpath.sv
// Module acc_cpu_dpath
// Register file of the core: program counter, instruction, address, buffer and
// accumulator registers, the interrupt enable flag and the two shadow registers
// used for the context save. Every register changes only on a strobe from the
// sequencer; assumes at most one source strobe per register per cycle.
module acc_cpu_dpath
    import acc_cpu_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 16,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cpu_ctrl_t         ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] pc_q,
    output logic [ADDR_W-1:0] mar_q,
    output logic [DATA_W-1:0] mbr_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [DATA_W-1:0] acc_q,
    output logic              ie_q,
    output logic [ADDR_W-1:0] shpc_q,
    output logic [DATA_W-1:0] shacc_q
);

    localparam logic [ADDR_W-1:0] PC_STEP = 1;

    logic [DATA_W-1:0] alu_y;
    logic [ADDR_W-1:0] ir_field;

    assign ir_field = ir_q[ADDR_W-1:0];

    acc_cpu_alu #(.W(DATA_W)) u_alu (
        .op_a   (acc_q),
        .op_b   (mbr_q),
        .add_en (ctl.acc_add),
        .result (alu_y)
    );

    // Program counter: vector, restore, jump or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (ctl.pc_vector) begin
            pc_q <= HANDLER_ADDR;
        end else if (ctl.pc_restore) begin
            pc_q <= shpc_q;
        end else if (ctl.pc_jump) begin
            pc_q <= ir_field;
        end else if (ctl.pc_inc) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    // Address register: drives the memory address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mar_q <= '0;
        end else if (ctl.mar_from_pc) begin
            mar_q <= pc_q;
        end else if (ctl.mar_from_ir) begin
            mar_q <= ir_field;
        end
    end

    // Instruction register: captures the fetched word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else if (ctl.ir_load) begin
            ir_q <= mem_rdata;
        end
    end

    // Buffer register: read data in, or accumulator out for a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mbr_q <= '0;
        end else if (ctl.mbr_from_mem) begin
            mbr_q <= mem_rdata;
        end else if (ctl.mbr_from_acc) begin
            mbr_q <= acc_q;
        end
    end

    // Accumulator: restore on return, else load or add result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (ctl.acc_restore) begin
            acc_q <= shacc_q;
        end else if (ctl.acc_load || ctl.acc_add) begin
            acc_q <= alu_y;
        end
    end

    // Shadow registers: hold the interrupted context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shpc_q  <= '0;
            shacc_q <= '0;
        end else if (ctl.ctx_save) begin
            shpc_q  <= pc_q;
            shacc_q <= acc_q;
        end
    end

    // Interrupt enable: cleared on entry, set by enable or return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_q <= 1'b0;
        end else if (ctl.ctx_save) begin
            ie_q <= 1'b0;
        end else if (ctl.ie_set) begin
            ie_q <= 1'b1;
        end
    end

endmodule

// File: rtl/acc_cpu.sv
// Module acc_cpu
// Top of the accumulator core. Joins the sequencer and the datapath and exposes
// the memory port plus the architectural registers. Assumes an external
// synchronous single-port memory with one cycle of read latency.
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      irq,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_we,
    output logic [OPC_W+ADDR_W-1:0]   mem_wdata,
    input  logic [OPC_W+ADDR_W-1:0]   mem_rdata,
    output logic [ADDR_W-1:0]         pc_o,
    output logic [OPC_W+ADDR_W-1:0]   acc_o,
    output logic                      irq_en_o
);

    localparam int DATA_W = OPC_W + ADDR_W;

    cpu_state_e        state;
    cpu_ctrl_t         ctl;
    logic [ADDR_W-1:0] pc;
    logic [ADDR_W-1:0] mar;
    logic [DATA_W-1:0] mbr;
    logic [DATA_W-1:0] ir;
    logic [DATA_W-1:0] acc;
    logic              ie;
    logic [ADDR_W-1:0] shpc;
    logic [DATA_W-1:0] shacc;
    logic [OPC_W-1:0]  opcode;

    assign opcode = ir[DATA_W-1:ADDR_W];

    acc_cpu_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .opcode   (opcode),
        .irq      (irq),
        .ie       (ie),
        .state_o  (state),
        .ctl_o    (ctl),
        .mem_we_o (mem_we)
    );

    acc_cpu_dpath #(
        .ADDR_W       (ADDR_W),
        .DATA_W       (DATA_W),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .pc_q      (pc),
        .mar_q     (mar),
        .mbr_q     (mbr),
        .ir_q      (ir),
        .acc_q     (acc),
        .ie_q      (ie),
        .shpc_q    (shpc),
        .shacc_q   (shacc)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mbr;
    assign pc_o      = pc;
    assign acc_o     = acc;
    assign irq_en_o  = ie;

endmodule

// File: rtl/acc_cpu_checker.sv
// Module acc_cpu_checker
// Temporal checks on the accumulator core, attached to every acc_cpu instance
// by the bind below. Observes ports and the sequencer state; drives nothing.
module acc_cpu_checker
    import acc_cpu_pkg::*;
#(
    parameter int                ADDR_W       = 12,
    parameter int                DATA_W       = 16,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 'h100
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input cpu_state_e        state,
    input logic [OPC_W-1:0]  opcode,
    input logic [ADDR_W-1:0] pc,
    input logic [DATA_W-1:0] acc,
    input logic              ie,
    input logic [ADDR_W-1:0] shpc,
    input logic [DATA_W-1:0] shacc,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata
);

    localparam logic [ADDR_W-1:0] PC_STEP = 1;

    logic seen_clk = 1'b0;

    // Marks that at least one edge has passed, so $past is meaningful.
    always_ff @(posedge clk) begin
        seen_clk <= 1'b1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        (seen_clk && !$past(rst_n)) |-> (pc == '0 && acc == '0 && !ie && !mem_we));

    assert_write_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    assert_write_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc));

    assert_fetch_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FLOAD) |=> (pc == $past(pc) + PC_STEP));

    assert_masked_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ICHECK && !ie) |=> (pc == $past(pc) && !ie));

    assert_vector_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ICHECK && ie && irq) |=>
        (pc == HANDLER_ADDR && !ie && shpc == $past(pc) && shacc == $past(acc)));

    assert_return_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECODE && opcode == OPC_RETI) |=>
        (ie && pc == $past(shpc) && acc == $past(shacc)));

endmodule

bind acc_cpu acc_cpu_checker #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .HANDLER_ADDR (HANDLER_ADDR)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq       (irq),
    .state     (state),
    .opcode    (opcode),
    .pc        (pc),
    .acc       (acc),
    .ie        (ie),
    .shpc      (shpc),
    .shacc     (shacc),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata)
);

// File: tb/acc_cpu_test.sv
// Bench acc_cpu_test
// Directed scenarios, one task each. A behavioural memory with one cycle of
// read latency serves the core; programs are written into it during reset.
module acc_cpu_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic [11:0] mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [11:0] pc_o;
    logic [15:0] acc_o;
    logic        irq_en_o;

    logic        ld_clr = 1'b0;
    logic        ld_we = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [15:0] ld_data = '0;
    logic [15:0] mem [0:4095];

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    acc_cpu uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq       (irq),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .pc_o      (pc_o),
        .acc_o     (acc_o),
        .irq_en_o  (irq_en_o)
    );

    // Memory: loader port has priority over the core's write.
    always @(posedge clk) begin
        if (ld_clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= '0;
        end else if (ld_we) begin
            mem[ld_addr] <= ld_data;
        end else if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
        end
        mem_rdata <= mem[mem_addr];
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [11:0] a, input logic [15:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic hold_reset();
        rst_n = 1'b0;
        ld_clr = 1'b1;
        @(negedge clk);
        ld_clr = 1'b0;
    endtask

    task automatic release_reset();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [15:0] in2(input logic [11:0] v, input logic [11:0] a, input logic [11:0] b);
        return (v == a || v == b) ? 16'd1 : 16'd0;
    endfunction

    // R1, R2, R3, R4, R5: arithmetic program with cycle-exact fetch check.
    task automatic t_load_add_store();
        irq = 1'b0;
        hold_reset();
        poke(12'h000, 16'h1020);
        poke(12'h001, 16'h5021);
        poke(12'h002, 16'h2022);
        poke(12'h003, 16'h8003);
        poke(12'h020, 16'h1234);
        poke(12'h021, 16'h0101);
        chk("R1 pc in reset", {4'h0, pc_o}, 16'h0000);
        chk("R1 acc in reset", acc_o, 16'h0000);
        chk("R1 irq_en in reset", {15'h0, irq_en_o}, 16'h0000);
        chk("R1 mem_we in reset", {15'h0, mem_we}, 16'h0000);
        release_reset();
        run(1);
        chk("R5 fetch address", {4'h0, mem_addr}, 16'h0000);
        run(2);
        chk("R5 pc step after fetch", {4'h0, pc_o}, 16'h0001);
        run(60);
        chk("R2 R3 acc after load+add", acc_o, 16'h1335);
        chk("R4 stored word", mem[12'h022], 16'h1335);
        chk("R6 spin at jump target", in2(pc_o, 12'h003, 12'h004), 16'h0001);
    endtask

    // R3: carry out of bit 15 is dropped; then R1: reset clears a live acc.
    task automatic t_wrap_and_reset();
        irq = 1'b0;
        hold_reset();
        poke(12'h000, 16'h1020);
        poke(12'h001, 16'h5021);
        poke(12'h002, 16'h2022);
        poke(12'h003, 16'h8003);
        poke(12'h020, 16'hFFFF);
        poke(12'h021, 16'h0002);
        release_reset();
        run(60);
        chk("R3 wrapped sum in acc", acc_o, 16'h0001);
        chk("R3 wrapped sum stored", mem[12'h022], 16'h0001);
        rst_n = 1'b0;
        run(2);
        chk("R1 acc cleared by reset", acc_o, 16'h0000);
        chk("R1 pc cleared by reset", {4'h0, pc_o}, 16'h0000);
    endtask

    // R6: a jump skips the store placed after it.
    task automatic t_jump_skip();
        irq = 1'b0;
        hold_reset();
        poke(12'h000, 16'h1020);
        poke(12'h001, 16'h8003);
        poke(12'h002, 16'h2022);
        poke(12'h003, 16'h2023);
        poke(12'h004, 16'h8004);
        poke(12'h020, 16'hAAAA);
        release_reset();
        run(60);
        chk("R6 skipped store untouched", mem[12'h022], 16'h0000);
        chk("R6 store at target", mem[12'h023], 16'hAAAA);
        chk("R6 spin at 4", in2(pc_o, 12'h004, 12'h005), 16'h0001);
    endtask

    // R10: undefined operation codes change neither acc nor memory.
    task automatic t_undefined();
        irq = 1'b0;
        hold_reset();
        poke(12'h000, 16'h1020);
        poke(12'h001, 16'h3021);
        poke(12'h002, 16'h9021);
        poke(12'h003, 16'h2022);
        poke(12'h004, 16'h8004);
        poke(12'h020, 16'h0042);
        poke(12'h021, 16'h7777);
        release_reset();
        run(60);
        chk("R10 acc unchanged", acc_o, 16'h0042);
        chk("R10 operand word unchanged", mem[12'h021], 16'h7777);
        chk("R10 execution continued", mem[12'h022], 16'h0042);
    endtask

    // R7: request held high while interrupts were never enabled.
    task automatic t_masked();
        hold_reset();
        poke(12'h000, 16'h1020);
        poke(12'h001, 16'h2022);
        poke(12'h002, 16'h8002);
        poke(12'h020, 16'h0005);
        poke(12'h100, 16'h2030);
        poke(12'h101, 16'h8101);
        irq = 1'b1;
        release_reset();
        run(100);
        chk("R7 handler marker untouched", mem[12'h030], 16'h0000);
        chk("R7 program completed", mem[12'h022], 16'h0005);
        chk("R7 enable still clear", {15'h0, irq_en_o}, 16'h0000);
        chk("R7 pc stays in program", in2(pc_o, 12'h002, 12'h003), 16'h0001);
        irq = 1'b0;
    endtask

    // R8, R9, R7: enable, take one interrupt, no nesting, restore on return.
    task automatic t_service();
        int waited;
        irq = 1'b0;
        hold_reset();
        poke(12'h000, 16'h7000);
        poke(12'h001, 16'h1020);
        poke(12'h002, 16'h8002);
        poke(12'h020, 16'h0055);
        poke(12'h100, 16'h2030);
        poke(12'h101, 16'h1031);
        poke(12'h102, 16'h5032);
        poke(12'h103, 16'h2031);
        poke(12'h104, 16'hF000);
        poke(12'h032, 16'h0001);
        release_reset();
        run(40);
        chk("R8 enable set by 0111", {15'h0, irq_en_o}, 16'h0001);
        irq = 1'b1;
        waited = 0;
        while (mem[12'h030] == 16'h0000 && waited < 100) begin
            run(1);
            waited++;
        end
        chk("R8 acc seen by handler", mem[12'h030], 16'h0055);
        chk("R8 enable cleared on entry", {15'h0, irq_en_o}, 16'h0000);
        chk("R8 pc in handler", {4'h0, pc_o[11:8], 8'h00}, 16'h0100);
        run(20);
        irq = 1'b0;
        run(80);
        chk("R7 handler entered once", mem[12'h031], 16'h0001);
        chk("R9 acc restored", acc_o, 16'h0055);
        chk("R9 enable set on return", {15'h0, irq_en_o}, 16'h0001);
        chk("R9 pc back in program", in2(pc_o, 12'h002, 12'h003), 16'h0001);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0001, 16'h0000);
        summary();
        $finish;
    end

    // Scenario sequence.
    initial begin
        @(negedge clk);
        t_load_add_store();
        t_wrap_and_reset();
        t_jump_skip();
        t_undefined();
        t_masked();
        t_service();
        summary();
        $finish;
    end

endmodule